// File: doc/BRIEF.md
# LPC I/O Address Match Decoder

This block decides whether an I/O address seen on the low pin count host bus belongs to one host-interface channel of a peripheral, and which register of that channel it names. The local CPU programs a 16-bit channel base through a byte-wide register port. The same port holds an enable bit for a group of sixteen bidirectional transfer registers. A separate channel enable input turns address comparison on and off.

Each received address is checked against the base with two rules.

- **Data/status rule.** Base bit 0 counts as zero and bit 2 is left out of the comparison. Received address bit 2 and the cycle direction then pick the register.
- **Bidirectional rule.** Base bit 4 is inverted and bits 3..0 are left out of the comparison. Address bits 3..0 then give the register index.

Results are captured on an address-valid strobe and held until the next strobe. Bus framing, the registers themselves, flags and interrupts live in neighbouring blocks.

Top module: `lpc_addr_decoder`

## Requirements
- R1: After reset both base bytes read back 0, and ds_hit_o, bd_hit_o, ds_sel_o and bd_idx_o are all 0.
- R2: reg_sel_i=0 reaches the low byte (base bits 7..0) and reg_sel_i=1 reaches the high byte (base bits 15..8). A write of reg_wdata_i with reg_wr_i=1 is read back on reg_rdata_o for the selected byte. Low-byte bit 2 stores and returns whatever is written.
- R3: While chan_en_i=1, register writes leave base bits 15..1 unchanged. Low-byte bit 0 (the bidirectional enable) is updated by a write in either state of chan_en_i.
- R4: A strobe taken while chan_en_i=0 gives ds_hit_o=0 and bd_hit_o=0.
- R5: With chan_en_i=1, ds_hit_o=1 exactly when addr_i equals the base on every bit except bit 2, with base bit 0 taken as 0.
- R6: With chan_en_i=1 and low-byte bit 0 set, bd_hit_o=1 exactly when addr_i[15:4] equals the base bits 15..4 with bit 4 inverted. With low-byte bit 0 clear, bd_hit_o stays 0.
- R7: On a data/status hit, ds_sel_o = {~io_write_i, addr_i[2]}:
  - 00: input data register on a write
  - 01: input data register on a write marked as a command
  - 10: output data register on a read
  - 11: status register on a read
  
  ds_sel_o is 0 when there is no data/status hit.
- R8: On a bidirectional hit, bd_idx_o = addr_i[3:0]. Otherwise bd_idx_o is 0.
- R9: The hit and select outputs take their new value at the clock edge that samples addr_vld_i=1 and hold it through cycles without a strobe.
- R10: ds_hit_o and bd_hit_o are never 1 together, and the data/status group has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 1 | Channel enable; also locks the address field |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Byte select: 0 low, 1 high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected byte read data |
| addr_vld_i | input | 1 | Received address valid strobe |
| addr_i | input | 16 | Received I/O address |
| io_write_i | input | 1 | Cycle direction: 1 write, 0 read |
| ds_hit_o | output | 1 | Data/status group hit |
| ds_sel_o | output | 2 | Data/status register select |
| bd_hit_o | output | 1 | Bidirectional group hit |
| bd_idx_o | output | 4 | Bidirectional register index |

## Verification
The bench builds the block with its default 16-bit address and 4-bit bidirectional index, so every pair of bytes is reachable through the register port. For each of six base values it sweeps all 256 low address bytes in both directions. It repeats each sweep with the high byte exact and with a high-bit and a low-bit mismatch. The bases cover base bit 0 set and clear, base bit 4 at both values, the reserved bit set, and an all-ones-like base, so both masking rules and every select code are reached. A further sweep with the channel off, and lock, hold and reset probes, exercise the register port and the strobe timing.

// File: rtl/lpc_dec_pkg.sv
package lpc_dec_pkg;
  typedef enum logic [1:0] {
    SEL_IDR     = 2'b00,
    SEL_IDR_CMD = 2'b01,
    SEL_ODR     = 2'b10,
    SEL_STR     = 2'b11
  } ds_sel_e;

  typedef struct packed {
    logic ds;
    logic bd;
  } hit_t;
endpackage

// File: rtl/lpc_base_regs.sv
module lpc_base_regs #(
  parameter int ADDR_W = 16,
  localparam int BYTES = ADDR_W / 8,
  localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] base_o
);
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    logic [7:0] q, nxt;
    always_comb begin
      nxt = q;
      if (wr_i && sel_i == SEL_W'(k)) begin
        if (!lock_i) nxt = wdata_i;
        else if (k == 0) nxt[0] = wdata_i[0]; // enable bit never locked
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end
    assign base_o[8*k +: 8] = q;
  end

  assign rdata_o = base_o[{sel_i, 3'b000} +: 8];

  AST_ADDR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> base_o[ADDR_W-1:1] == $past(base_o[ADDR_W-1:1])); // R3
endmodule

// File: rtl/lpc_addr_match.sv
module lpc_addr_match #(
  parameter int ADDR_W     = 16,
  parameter int DS_SEL_BIT = 2,
  parameter int BD_IDX_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              bd_en_i,
  output logic              ds_m_o,
  output logic              bd_m_o
);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DS_CARE = ~(ONE << DS_SEL_BIT);
  localparam logic [ADDR_W-1:0] DS_ZERO = ~ONE;
  localparam logic [ADDR_W-1:0] BD_FLIP = ONE << BD_IDX_W;
  localparam logic [ADDR_W-1:0] BD_CARE = ~(BD_FLIP - ONE);

  logic [ADDR_W-1:0] ds_ref, bd_ref;
  assign ds_ref = base_i & DS_ZERO;
  assign bd_ref = base_i ^ BD_FLIP;

  assign ds_m_o = ((addr_i ^ ds_ref) & DS_CARE) == '0;
  assign bd_m_o = bd_en_i && (((addr_i ^ bd_ref) & BD_CARE) == '0);
endmodule

// File: rtl/lpc_addr_decoder.sv
module lpc_addr_decoder
  import lpc_dec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DS_SEL_BIT = 2,
  parameter int BD_IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_en_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_write_i,
  output logic              ds_hit_o,
  output logic [1:0]        ds_sel_o,
  output logic              bd_hit_o,
  output logic [BD_IDX_W-1:0] bd_idx_o
);
  logic [ADDR_W-1:0] base;
  logic              bd_en, ds_m, bd_m;
  hit_t              hit_d, hit_q;
  ds_sel_e           sel_d, sel_q;
  logic [BD_IDX_W-1:0] idx_d, idx_q;

  lpc_base_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (chan_en_i),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base)
  );

  assign bd_en = base[0];

  lpc_addr_match #(
    .ADDR_W(ADDR_W), .DS_SEL_BIT(DS_SEL_BIT), .BD_IDX_W(BD_IDX_W)
  ) u_match (
    .addr_i  (addr_i),
    .base_i  (base),
    .bd_en_i (bd_en),
    .ds_m_o  (ds_m),
    .bd_m_o  (bd_m)
  );

  always_comb begin
    hit_d = '0;
    sel_d = SEL_IDR;
    idx_d = '0;
    if (chan_en_i) begin
      if (ds_m) begin  // data/status group wins
        hit_d.ds = 1'b1;
        sel_d    = ds_sel_e'({~io_write_i, addr_i[DS_SEL_BIT]});
      end else if (bd_m) begin
        hit_d.bd = 1'b1;
        idx_d    = addr_i[BD_IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= '0;
      sel_q <= SEL_IDR;
      idx_q <= '0;
    end else if (addr_vld_i) begin
      hit_q <= hit_d;
      sel_q <= sel_d;
      idx_q <= idx_d;
    end
  end

  assign ds_hit_o = hit_q.ds;
  assign bd_hit_o = hit_q.bd;
  assign ds_sel_o = sel_q;
  assign bd_idx_o = idx_q;

  AST_HIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ds_hit_o, bd_hit_o})); // R10
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_i |=> $stable({ds_hit_o, bd_hit_o, ds_sel_o, bd_idx_o})); // R9
  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && !chan_en_i) |=> (!ds_hit_o && !bd_hit_o)); // R4
  AST_BD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && !bd_en) |=> !bd_hit_o); // R6
  AST_BD_IDX_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && chan_en_i && !ds_m && bd_m) |=> bd_idx_o == $past(addr_i[BD_IDX_W-1:0])); // R8
endmodule

// File: tb/lpc_addr_decoder_tb.sv
module lpc_addr_decoder_tb;
  logic        clk_i = 0, rst_ni = 0, chan_en_i = 0, reg_wr_i = 0, reg_sel_i = 0;
  logic [7:0]  reg_wdata_i = 0, reg_rdata_o;
  logic        addr_vld_i = 0, io_write_i = 0;
  logic [15:0] addr_i = 0;
  logic        ds_hit_o, bd_hit_o;
  logic [1:0]  ds_sel_o;
  logic [3:0]  bd_idx_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lpc_addr_decoder u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic s, logic [7:0] d);
    @(negedge clk_i); reg_wr_i = 1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 0;
  endtask

  task automatic rd_chk(string req, logic s, logic [7:0] exp);
    reg_sel_i = s; #1;
    chk(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic set_base(logic [15:0] b);
    chan_en_i = 0;
    wr_reg(0, b[7:0]);
    wr_reg(1, b[15:8]);
    chan_en_i = 1;
  endtask

  task automatic strobe_chk(logic [15:0] base, logic [15:0] a, logic w, logic en);
    logic ds_e, bd_e;
    logic [1:0] sel_e;
    logic [3:0] idx_e;
    @(negedge clk_i); addr_i = a; io_write_i = w; addr_vld_i = 1;
    @(negedge clk_i); addr_vld_i = 0;
    ds_e  = en && ((a & 16'hFFFB) == (base & 16'hFFFA));                    // R5
    bd_e  = en && !ds_e && base[0] && ((a & 16'hFFF0) == ((base ^ 16'h0010) & 16'hFFF0)); // R6 R10
    sel_e = ds_e ? {~w, a[2]} : 2'b00;                                       // R7
    idx_e = bd_e ? a[3:0] : 4'h0;                                            // R8
    chk("R5", 32'(ds_hit_o), 32'(ds_e));
    chk("R6", 32'(bd_hit_o), 32'(bd_e));
    chk("R7", 32'(ds_sel_o), 32'(sel_e));
    chk("R8", 32'(bd_idx_o), 32'(idx_e));
    chk("R10", 32'(ds_hit_o & bd_hit_o), 32'd0);
  endtask

  task automatic sweep(logic [15:0] base);
    logic [7:0] his [3];
    his[0] = base[15:8]; his[1] = base[15:8] ^ 8'h01; his[2] = base[15:8] ^ 8'h80;
    for (int h = 0; h < 3; h++)
      for (int lo = 0; lo < 256; lo++)
        for (int w = 0; w < 2; w++)
          strobe_chk(base, {his[h], 8'(lo)}, w[0], 1'b1);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [6];
    bases = '{16'h0CA2, 16'h0CA3, 16'h0CB3, 16'h0A27, 16'hFFFD, 16'h0001};
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd_chk("R1", 0, 8'h00);
    rd_chk("R1", 1, 8'h00);
    chk("R1", 32'({ds_hit_o, bd_hit_o, ds_sel_o, bd_idx_o}), 32'd0);
    // R2 register port, reserved bit keeps value
    wr_reg(0, 8'h5D); wr_reg(1, 8'hA6);
    rd_chk("R2", 0, 8'h5D);
    rd_chk("R2", 1, 8'hA6);
    wr_reg(0, 8'h04);
    rd_chk("R2", 0, 8'h04);
    // R3 lock while channel enabled
    wr_reg(0, 8'h5C); wr_reg(1, 8'h3A);
    chan_en_i = 1;
    wr_reg(1, 8'hFF);
    rd_chk("R3", 1, 8'h3A);
    wr_reg(0, 8'hA3);
    rd_chk("R3", 0, 8'h5D);
    wr_reg(0, 8'hFE);
    rd_chk("R3", 0, 8'h5C);
    // R9 timing: result appears after strobe edge, holds without strobe
    set_base(16'h0CA2);
    @(negedge clk_i); addr_i = 16'h0CA6; io_write_i = 0; addr_vld_i = 1;
    chk("R9", 32'(ds_hit_o), 32'd0);
    @(negedge clk_i); addr_vld_i = 0; addr_i = 16'h1234;
    chk("R9", 32'({ds_hit_o, ds_sel_o}), 32'b111);
    repeat (3) @(negedge clk_i);
    chk("R9", 32'({ds_hit_o, ds_sel_o}), 32'b111);
    // R4 channel disabled: no hits
    chan_en_i = 0;
    for (int lo = 0; lo < 256; lo++) strobe_chk(16'h0CA3, {8'h0C, 8'(lo)}, lo[0], 1'b0);
    wr_reg(0, 8'hA3);
    for (int lo = 0; lo < 256; lo++) strobe_chk(16'h0CA3, {8'h0C, 8'(lo)}, lo[0], 1'b0);
    // R5..R8, R10 sweeps
    foreach (bases[i]) begin
      set_base(bases[i]);
      sweep(bases[i]);
    end
    // R1 reset clears outputs
    set_base(16'h0CA3);
    strobe_chk(16'h0CA3, 16'h0CB5, 1'b0, 1'b1);
    rst_ni = 0; #1;
    chk("R1", 32'({ds_hit_o, bd_hit_o, ds_sel_o, bd_idx_o}), 32'd0);
    rd_chk("R1", 0, 8'h00);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule